// File: doc/BRIEF.md
# Host-to-Local Address Remap Window

This block sits between a host-side firmware-space bus and a local memory space. It receives host request addresses and decides, for each one, whether it falls inside a single programmable window. When it does, the block builds a local address by merging fixed destination bits from a base register with selected bits of the request. Remapping works on 64 KiB granules. Bits [15:0] of the address always pass through untouched.

Software sets the window through three 32-bit registers: a control register, a base register and a mask register. The base register holds the local destination granule in its upper half and the host-side window start granule in its lower half. In the mask register, the upper half marks request bits that are replaced by base bits, and the lower half marks request bits that are kept. For a power-of-two window of `size` bytes, software writes `~(size-1)` into the upper mask half and `(size>>16)-1` into the lower half. Forwarding stays off until two enable bits in the control register are both set. Each request gets a registered answer one cycle later: hit, miss, or disabled.

Top module: `remap_window`

## Requirements
- R1: After a synchronous active-low reset, all three registers read as zero, `rsp_vld` is low, and forwarding is disabled.
- R2: The control register is at byte offset 0x0, the base register at 0x8 and the mask register at 0xC. A read returns the full 32-bit value last written there.
- R3: A write to any other offset (for example 0x4 or 0x1) changes no register, and a read from such an offset returns zero.
- R4: A request is forwarded only when control bit 8 and control bit 10 are both 1. Otherwise its response has `rsp_dis`=1 and `rsp_hit`=0. Other control bits have no effect.
- R5: `rsp_vld` is high in the cycle after each cycle in which `req_vld` is high, and low otherwise. Back-to-back requests get back-to-back responses.
- R6: An enabled request hits when req[31:16] equals base[15:0] at every bit where mask[31:16] is 1. Otherwise it misses.
- R7: On a hit, `rsp_addr`[31:16] = (base[31:16] & mask[31:16]) | (req[31:16] & mask[15:0]), and `rsp_addr`[15:0] = req[15:0].
- R8: A miss or a disabled response has `rsp_hit`=0 and `rsp_addr`=0. A miss has `rsp_dis`=0, and `rsp_hit` and `rsp_dis` are never high together.
- R9: A register write affects requests presented in the cycle after the write. A request in the same cycle as the write is answered with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_vld | input | 1 | Host request valid |
| req_addr | input | 32 | Host request address |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Request hit the window and was forwarded |
| rsp_dis | output | 1 | Forwarding was disabled for this request |
| rsp_addr | output | 32 | Translated local address (zero unless hit) |

## Verification
The assertions assume that `req_vld` and `req_addr` carry no unknown values once reset is released. They also assume that reset is held for at least one clock edge, so the registered outputs start from a known state. The bench drives every input from a defined value at time zero and changes stimulus only on falling edges. It programs masks the way software does for power-of-two windows, and it also applies an irregular mask, so the merge equation is checked bit by bit and not only for the well-formed layout.

// File: rtl/remap_pkg.sv
// remap_pkg: shared offsets, control bit positions and register select type
// for the host-to-local remap window. Assumes byte-addressed 32-bit registers.
package remap_pkg;
    localparam int OFF_CTRL  = 'h0;
    localparam int OFF_BASE  = 'h8;
    localparam int OFF_MASK  = 'hC;
    localparam int EN_A_BIT  = 8;
    localparam int EN_B_BIT  = 10;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_BASE = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/remap_cfg_regs.sv
// remap_cfg_regs: holds the control, base and mask registers. Decodes the
// offset, applies writes at the clock edge and returns read data without delay.
// Assumes: one access per cycle; unknown offsets read zero and ignore writes.
module remap_cfg_regs
    import remap_pkg::*;
#(
    parameter int CFG_AW = 4,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [REG_W-1:0]  base_q,
    output logic [REG_W-1:0]  mask_q,
    output logic              fwd_en
);
    logic [REG_W-1:0] ctrl_q;
    reg_sel_e         sel;

    // Decode the byte offset into a register select.
    always_comb begin
        if (cfg_addr == CFG_AW'(OFF_CTRL))      sel = SEL_CTRL;
        else if (cfg_addr == CFG_AW'(OFF_BASE)) sel = SEL_BASE;
        else if (cfg_addr == CFG_AW'(OFF_MASK)) sel = SEL_MASK;
        else                                    sel = SEL_NONE;
    end

    // Register update: reset to zero, then write the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            base_q <= '0;
            mask_q <= '0;
        end else if (cfg_wr) begin
            case (sel)
                SEL_CTRL: ctrl_q <= cfg_wdata;
                SEL_BASE: base_q <= cfg_wdata;
                SEL_MASK: mask_q <= cfg_wdata;
                default:  ;
            endcase
        end
    end

    // Read mux: zero for unknown offsets.
    always_comb begin
        case (sel)
            SEL_CTRL: cfg_rdata = ctrl_q;
            SEL_BASE: cfg_rdata = base_q;
            SEL_MASK: cfg_rdata = mask_q;
            default:  cfg_rdata = '0;
        endcase
    end

    // Forwarding needs both enable bits.
    assign fwd_en = ctrl_q[EN_A_BIT] & ctrl_q[EN_B_BIT];

    // R3: a write to an unknown offset leaves every register unchanged.
    assert_undef_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(base_q) && $stable(mask_q)));

    // R1: reset clears every register.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && base_q == '0 && mask_q == '0));
endmodule

// File: rtl/remap_xlate.sv
// remap_xlate: per-request window match and address merge, registered once.
// Assumes: base/mask layout of two SEG_W halves; low GRAN_LSB bits pass through.
module remap_xlate #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fwd_en,
    input  logic [2*(ADDR_W-GRAN_LSB)-1:0] base_q,
    input  logic [2*(ADDR_W-GRAN_LSB)-1:0] mask_q,
    input  logic                         req_vld,
    input  logic [ADDR_W-1:0]            req_addr,
    output logic                         rsp_vld,
    output logic                         rsp_hit,
    output logic                         rsp_dis,
    output logic [ADDR_W-1:0]            rsp_addr
);
    localparam int SEG_W = ADDR_W - GRAN_LSB;
    localparam int REG_W = 2 * SEG_W;

    logic [SEG_W-1:0] req_seg, loc_hi, win_start, sub_m, keep_m;
    logic [SEG_W-1:0] merged, mism;
    logic             in_win, hit_c;

    assign req_seg   = req_addr[ADDR_W-1:GRAN_LSB];
    assign loc_hi    = base_q[REG_W-1:SEG_W];
    assign win_start = base_q[SEG_W-1:0];
    assign sub_m     = mask_q[REG_W-1:SEG_W];
    assign keep_m    = mask_q[SEG_W-1:0];

    // Per-bit merge of destination bits and kept request bits, and the match test.
    for (genvar i = 0; i < SEG_W; i++) begin : g_seg
        assign merged[i] = (loc_hi[i] & sub_m[i]) | (req_seg[i] & keep_m[i]);
        assign mism[i]   = sub_m[i] & (req_seg[i] ^ win_start[i]);
    end

    assign in_win = ~|mism;
    assign hit_c  = fwd_en & in_win;

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_hit  <= 1'b0;
            rsp_dis  <= 1'b0;
            rsp_addr <= '0;
        end else begin
            rsp_vld  <= req_vld;
            rsp_hit  <= req_vld & hit_c;
            rsp_dis  <= req_vld & ~fwd_en;
            rsp_addr <= (req_vld && hit_c) ? {merged, req_addr[GRAN_LSB-1:0]} : '0;
        end
    end

    // R5: every request gets exactly one response one cycle later.
    assert_vld_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld == $past(req_vld && rst_n));

    // R4: a hit only when forwarding was enabled at request time.
    assert_hit_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(fwd_en));

    // R7: the low granule bits pass through unchanged on a hit.
    assert_low_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_addr[GRAN_LSB-1:0] == $past(req_addr[GRAN_LSB-1:0]));

    // R8: hit and disabled are exclusive; no address unless hit.
    assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_dis) && (rsp_hit || rsp_addr == '0));
endmodule

// File: rtl/remap_window.sv
// remap_window: top of the host-to-local remap window. Connects the register
// block to the translation stage. Assumes synchronous active-low reset.
module remap_window #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 16,
    parameter int CFG_AW   = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_wr,
    input  logic [CFG_AW-1:0]                   cfg_addr,
    input  logic [2*(ADDR_W-GRAN_LSB)-1:0]      cfg_wdata,
    output logic [2*(ADDR_W-GRAN_LSB)-1:0]      cfg_rdata,
    input  logic                                req_vld,
    input  logic [ADDR_W-1:0]                   req_addr,
    output logic                                rsp_vld,
    output logic                                rsp_hit,
    output logic                                rsp_dis,
    output logic [ADDR_W-1:0]                   rsp_addr
);
    localparam int REG_W = 2 * (ADDR_W - GRAN_LSB);

    logic [REG_W-1:0] base_q, mask_q;
    logic             fwd_en;

    remap_cfg_regs #(.CFG_AW(CFG_AW), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .base_q(base_q), .mask_q(mask_q), .fwd_en(fwd_en)
    );

    remap_xlate #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_xlate (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .base_q(base_q), .mask_q(mask_q),
        .req_vld(req_vld), .req_addr(req_addr),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_dis(rsp_dis), .rsp_addr(rsp_addr)
    );
endmodule

// File: tb/sim_remap_window.sv
// Directed bench for remap_window: one task per scenario, each checks itself.
module sim_remap_window;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_vld = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_vld, rsp_hit, rsp_dis;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] sh_ctrl = '0, sh_base = '0, sh_mask = '0;

    remap_window u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_vld(req_vld), .req_addr(req_addr),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_dis(rsp_dis), .rsp_addr(rsp_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Expected response from the requirement equations.
    task automatic expect_rsp(input string tag, input logic [31:0] a,
                              input logic [31:0] c, input logic [31:0] b, input logic [31:0] m);
        logic en, hit;
        logic [31:0] ea;
        en  = c[8] & c[10];
        hit = en && (((a[31:16] ^ b[15:0]) & m[31:16]) == 16'h0);
        ea  = hit ? {(b[31:16] & m[31:16]) | (a[31:16] & m[15:0]), a[15:0]} : 32'h0;
        check({tag, " vld"}, {31'h0, rsp_vld}, 32'h1);
        check({tag, " hit"}, {31'h0, rsp_hit}, {31'h0, hit});
        check({tag, " dis"}, {31'h0, rsp_dis}, {31'h0, ~en});
        check({tag, " addr"}, rsp_addr, ea);
    endtask

    task automatic wr(input logic [3:0] off, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        if (off == 4'h0) sh_ctrl = d;
        else if (off == 4'h8) sh_base = d;
        else if (off == 4'hC) sh_mask = d;
    endtask

    task automatic rd(input string tag, input logic [3:0] off, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = off;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic req(input string tag, input logic [31:0] a);
        @(negedge clk);
        req_vld = 1'b1; req_addr = a;
        @(posedge clk); #1;
        req_vld = 1'b0;
        expect_rsp(tag, a, sh_ctrl, sh_base, sh_mask);
    endtask

    task automatic t_reset();
        rd("R1 ctrl reset", 4'h0, 32'h0);
        rd("R1 base reset", 4'h8, 32'h0);
        rd("R1 mask reset", 4'hC, 32'h0);
        check("R1 rsp_vld reset", {31'h0, rsp_vld}, 32'h0);
        req("R1 disabled after reset", 32'h1234_5678);
    endtask

    task automatic t_regs();
        wr(4'h0, 32'hA5A5_0000); rd("R2 ctrl readback", 4'h0, 32'hA5A5_0000);
        wr(4'h8, 32'hDEAD_BEEF); rd("R2 base readback", 4'h8, 32'hDEAD_BEEF);
        wr(4'hC, 32'h0F0F_F0F0); rd("R2 mask readback", 4'hC, 32'h0F0F_F0F0);
    endtask

    task automatic t_undef();
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h1, 32'h1111_1111);
        rd("R3 read 0x4 zero", 4'h4, 32'h0);
        rd("R3 read 0xF zero", 4'hF, 32'h0);
        rd("R3 ctrl untouched", 4'h0, 32'hA5A5_0000);
        rd("R3 base untouched", 4'h8, 32'hDEAD_BEEF);
        rd("R3 mask untouched", 4'hC, 32'h0F0F_F0F0);
    endtask

    task automatic t_enable();
        wr(4'h8, 32'h9830_0E30);
        wr(4'hC, 32'hFFF0_000F);
        wr(4'h0, 32'h0000_0100); req("R4 only bit 8", 32'h0E30_0010);
        wr(4'h0, 32'h0000_0400); req("R4 only bit 10", 32'h0E30_0010);
        wr(4'h0, 32'hFFFF_FAFF); req("R4 other bits set", 32'h0E30_0010);
        wr(4'h0, 32'h0000_0500); req("R4 both enabled", 32'h0E30_0010);
    endtask

    task automatic t_window();
        req("R6 R7 hit in 1MiB window", 32'h0E3A_BCDE);
        req("R6 R7 hit window top", 32'h0E3F_FFFF);
        req("R6 R8 miss above", 32'h0E40_0000);
        req("R6 R8 miss below", 32'h0E2F_FFFF);
        wr(4'h8, 32'h4000_2000); wr(4'hC, 32'hFFFF_0000);
        req("R6 R7 64KiB window hit", 32'h2000_8001);
        req("R8 64KiB window miss", 32'h2001_0000);
        wr(4'h8, 32'hABCD_1234); wr(4'hC, 32'hF0F0_0F0F);
        req("R7 irregular mask hit", 32'h1A3B_5555);
        req("R8 irregular mask miss", 32'h2234_0000);
        wr(4'hC, 32'h0000_FFFF);
        req("R6 R7 zero sub mask passes", 32'h7654_3210);
    endtask

    task automatic t_latency();
        @(negedge clk);
        req_vld = 1'b1; req_addr = 32'h0000_0001;
        @(posedge clk); #1;
        expect_rsp("R5 back-to-back first", 32'h0000_0001, sh_ctrl, sh_base, sh_mask);
        req_addr = 32'hFFFF_0002;
        @(posedge clk); #1;
        req_vld = 1'b0;
        expect_rsp("R5 back-to-back second", 32'hFFFF_0002, sh_ctrl, sh_base, sh_mask);
        @(posedge clk); #1;
        check("R5 idle no vld", {31'h0, rsp_vld}, 32'h0);
    endtask

    task automatic t_timing();
        logic [31:0] oc, ob, om;
        oc = sh_ctrl; ob = sh_base; om = sh_mask;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 4'h0; cfg_wdata = 32'h0;
        req_vld = 1'b1; req_addr = 32'h5555_AAAA;
        @(posedge clk); #1;
        cfg_wr = 1'b0; req_vld = 1'b0;
        expect_rsp("R9 same-cycle write uses old", 32'h5555_AAAA, oc, ob, om);
        sh_ctrl = 32'h0;
        req("R9 next cycle uses new", 32'h5555_AAAA);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_undef();
        t_enable();
        t_window();
        t_latency();
        t_timing();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule